// File: doc/BRIEF.md
# Staged serial-channel configuration register bank

This block holds the configuration of one asynchronous serial channel: a mode byte, a port-value byte, a data-format byte (with the break-transmit control in its top bit) and a 10-bit baud divisor. Rewriting these while a character is on the line can corrupt that character. So every host write to one of them lands in a staging copy, and the staged set is moved into the live registers together, only while the transmitter reports that it is idle.

The host side is a single-cycle write strobe with a 3-bit address and a byte of data. The transmitter supplies a level that is high while its send pool is empty and nothing is being shifted out. The live registers drive the channel. The divisor packs a 6-bit mantissa in bits 5:0 and a 4-bit exponent in bits 9:6. Its low byte forms the baud register. Its two top bits sit in bits 7:6 of a second control register, and the host writes bits 5:0 of that register directly. A commit rewrites bits 7:6 only and leaves bits 5:0 as they are.

Top module: `ser_cfg_stage`

## Requirements
- R1: After reset: mode_q=8'h00, pval_q=8'h16, dfmt_q=8'h03, baud_lo_q=8'h00, ctl2_q=8'h00, and cfg_pending=0. The staging copies hold the same values.
- R2: A write strobe to a staged address raises cfg_pending at the clock edge that captures the write. The staged addresses are 0 (mode), 1 (port value), 2 (data format), 3 (divisor bits 7:0) and 4 (divisor bits 9:8 from data bits 1:0).
- R3: While tx_idle is low, mode_q, pval_q, dfmt_q, baud_lo_q and ctl2_q[7:6] do not change, and cfg_pending stays high once it is set.
- R4: At an edge where cfg_pending is high and tx_idle is high, all five staged values are copied to the live registers together, and cfg_pending is cleared unless a staged write is captured at that same edge. When tx_idle is already high, a write captured at edge k is live after edge k+1.
- R5: The divisor's bits 7:0 appear on baud_lo_q, and its bits 9:8 appear on ctl2_q[7:6], after a commit.
- R6: A write to address 5 loads data bits 5:0 into ctl2_q[5:0] at the capturing edge, whatever tx_idle is, and does not set cfg_pending. A commit leaves ctl2_q[5:0] unchanged.
- R7: The break-transmit control, dfmt_q[7], is deferred like the rest of the data-format byte. It does not reach the live register while tx_idle is low.
- R8: A staged write captured at a commit edge does not take part in that commit. The live registers take the previously staged values, cfg_pending stays high, and the new value is committed at the next idle edge.
- R9: Writes to addresses 6 and 7 change no live register and do not set cfg_pending.
- R10: Several staged writes before a commit are all committed at one edge, and the last write to each address wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| tx_idle | input | 1 | High while the transmitter is empty and idle |
| mode_q | output | 8 | Live mode register |
| pval_q | output | 8 | Live port-value register |
| dfmt_q | output | 8 | Live data-format register, bit 7 is break transmit |
| baud_lo_q | output | 8 | Live divisor bits 7:0 |
| ctl2_q | output | 8 | Live control register: bits 7:6 are divisor bits 9:8, bits 5:0 are direct |
| cfg_pending | output | 1 | Staged values are waiting for a commit |

## Verification
Results arrive at three distinct times. cfg_pending and the direct ctl2_q[5:0] bits change one edge after the write. Committed live values change one edge after a cycle in which cfg_pending and tx_idle are both high, which is two edges after a write when the transmitter is already idle. The bench drives inputs on the falling edge and samples on a falling edge. Each check is placed at the falling edge that follows the specific rising edge where the requirement says the value is due. For the overlap case of R8, the bench also samples one edge earlier, to show that the old staged value was committed and the new one is still waiting.

// File: rtl/ser_cfg_stage_pkg.sv
package ser_cfg_stage_pkg;
  localparam int ADDR_W = 3;
  // register select codes
  localparam logic [ADDR_W-1:0] SEL_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] SEL_PVAL = 3'd1;
  localparam logic [ADDR_W-1:0] SEL_DFMT = 3'd2;
  localparam logic [ADDR_W-1:0] SEL_DIVL = 3'd3;
  localparam logic [ADDR_W-1:0] SEL_DIVH = 3'd4;
  localparam logic [ADDR_W-1:0] SEL_CTL2 = 3'd5;
  localparam int NUM_BYTE_SHADOWS = 3;  // mode, port value, data format
endpackage

// File: rtl/ser_cfg_shadow.sv
module ser_cfg_shadow
  import ser_cfg_stage_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W = 10,
  parameter logic [DATA_W-1:0] MODE_RST = '0,
  parameter logic [DATA_W-1:0] PVAL_RST = '0,
  parameter logic [DATA_W-1:0] DFMT_RST = '0,
  parameter logic [DIV_W-1:0] DIV_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sh_mode,
  output logic [DATA_W-1:0] sh_pval,
  output logic [DATA_W-1:0] sh_dfmt,
  output logic [DIV_W-1:0]  sh_div,
  output logic              staged_wr
);
  localparam int HI_W = DIV_W - DATA_W;

  logic [DATA_W-1:0] byte_q [NUM_BYTE_SHADOWS];
  logic [DATA_W-1:0] byte_rst [NUM_BYTE_SHADOWS];

  assign byte_rst[0] = MODE_RST;
  assign byte_rst[1] = PVAL_RST;
  assign byte_rst[2] = DFMT_RST;

  genvar g;
  generate
    for (g = 0; g < NUM_BYTE_SHADOWS; g++) begin : g_byte
      logic ld;
      assign ld = wr_en && (wr_addr == ADDR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  byte_q[g] <= byte_rst[g];
        else if (ld) byte_q[g] <= wr_data;
      end
    end
  endgenerate

  logic ld_lo, ld_hi;
  logic [DATA_W-1:0] div_lo_q;
  logic [HI_W-1:0]   div_hi_q;

  assign ld_lo = wr_en && (wr_addr == SEL_DIVL);
  assign ld_hi = wr_en && (wr_addr == SEL_DIVH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_lo_q <= DIV_RST[DATA_W-1:0];
    else if (ld_lo) div_lo_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_hi_q <= DIV_RST[DIV_W-1:DATA_W];
    else if (ld_hi) div_hi_q <= wr_data[HI_W-1:0];
  end

  assign sh_mode   = byte_q[0];
  assign sh_pval   = byte_q[1];
  assign sh_dfmt   = byte_q[2];
  assign sh_div    = {div_hi_q, div_lo_q};
  assign staged_wr = wr_en && (wr_addr <= SEL_DIVH);
endmodule

// File: rtl/ser_cfg_commit_ctl.sv
module ser_cfg_commit_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic staged_wr,
  input  logic tx_idle,
  output logic commit,
  output logic pending
);
  logic pending_d;

  assign commit = pending && tx_idle;

  always_comb begin
    pending_d = pending;
    if (commit)    pending_d = 1'b0;
    if (staged_wr) pending_d = 1'b1;  // a write at a commit edge stays queued
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pending_d;
  end
endmodule

// File: rtl/ser_cfg_live.sv
module ser_cfg_live
  import ser_cfg_stage_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W = 10,
  parameter logic [DATA_W-1:0] MODE_RST = '0,
  parameter logic [DATA_W-1:0] PVAL_RST = '0,
  parameter logic [DATA_W-1:0] DFMT_RST = '0,
  parameter logic [DIV_W-1:0]  DIV_RST = '0,
  parameter logic [DATA_W-1:0] CTL2_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              direct_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] sh_mode,
  input  logic [DATA_W-1:0] sh_pval,
  input  logic [DATA_W-1:0] sh_dfmt,
  input  logic [DIV_W-1:0]  sh_div,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] pval_q,
  output logic [DATA_W-1:0] dfmt_q,
  output logic [DATA_W-1:0] baud_lo_q,
  output logic [DATA_W-1:0] ctl2_q
);
  localparam int HI_W = DIV_W - DATA_W;
  localparam int LO_W = DATA_W - HI_W;

  logic [HI_W-1:0] ctl2_hi_q;
  logic [LO_W-1:0] ctl2_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_RST;
      pval_q    <= PVAL_RST;
      dfmt_q    <= DFMT_RST;
      baud_lo_q <= DIV_RST[DATA_W-1:0];
      ctl2_hi_q <= CTL2_RST[DATA_W-1:LO_W];
    end else if (commit) begin
      mode_q    <= sh_mode;
      pval_q    <= sh_pval;
      dfmt_q    <= sh_dfmt;
      baud_lo_q <= sh_div[DATA_W-1:0];
      ctl2_hi_q <= sh_div[DIV_W-1:DATA_W];
    end
  end

  // lower control bits are host-direct and untouched by a commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctl2_lo_q <= CTL2_RST[LO_W-1:0];
    else if (direct_wr) ctl2_lo_q <= wr_data[LO_W-1:0];
  end

  assign ctl2_q = {ctl2_hi_q, ctl2_lo_q};
endmodule

// File: rtl/ser_cfg_stage.sv
module ser_cfg_stage
  import ser_cfg_stage_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W = 10,
  parameter logic [DATA_W-1:0] MODE_RST = 8'h00,
  parameter logic [DATA_W-1:0] PVAL_RST = 8'h16,
  parameter logic [DATA_W-1:0] DFMT_RST = 8'h03,
  parameter logic [DIV_W-1:0]  DIV_RST  = 10'h000,
  parameter logic [DATA_W-1:0] CTL2_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_idle,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] pval_q,
  output logic [DATA_W-1:0] dfmt_q,
  output logic [DATA_W-1:0] baud_lo_q,
  output logic [DATA_W-1:0] ctl2_q,
  output logic              cfg_pending
);
  logic [DATA_W-1:0] sh_mode, sh_pval, sh_dfmt;
  logic [DIV_W-1:0]  sh_div;
  logic              staged_wr, commit, direct_wr;

  assign direct_wr = wr_en && (wr_addr == SEL_CTL2);

  ser_cfg_shadow #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .MODE_RST(MODE_RST),
    .PVAL_RST(PVAL_RST), .DFMT_RST(DFMT_RST), .DIV_RST(DIV_RST)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sh_mode(sh_mode), .sh_pval(sh_pval),
    .sh_dfmt(sh_dfmt), .sh_div(sh_div), .staged_wr(staged_wr)
  );

  ser_cfg_commit_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .staged_wr(staged_wr), .tx_idle(tx_idle),
    .commit(commit), .pending(cfg_pending)
  );

  ser_cfg_live #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .MODE_RST(MODE_RST),
    .PVAL_RST(PVAL_RST), .DFMT_RST(DFMT_RST), .DIV_RST(DIV_RST),
    .CTL2_RST(CTL2_RST)
  ) u_live (
    .clk(clk), .rst_n(rst_n), .commit(commit), .direct_wr(direct_wr),
    .wr_data(wr_data), .sh_mode(sh_mode), .sh_pval(sh_pval),
    .sh_dfmt(sh_dfmt), .sh_div(sh_div), .mode_q(mode_q),
    .pval_q(pval_q), .dfmt_q(dfmt_q), .baud_lo_q(baud_lo_q),
    .ctl2_q(ctl2_q)
  );
endmodule

// File: rtl/ser_cfg_stage_chk.sv
module ser_cfg_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       tx_idle,
  input logic [7:0] mode_q,
  input logic [7:0] pval_q,
  input logic [7:0] dfmt_q,
  input logic [7:0] baud_lo_q,
  input logic [7:0] ctl2_q,
  input logic       cfg_pending
);
  logic stg;
  assign stg = wr_en && (wr_addr < 3'd5);

  assert_stage_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stg |=> cfg_pending);

  assert_busy_holds_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_idle |=> ($stable(mode_q) && $stable(pval_q) && $stable(dfmt_q)
                  && $stable(baud_lo_q) && $stable(ctl2_q[7:6])));

  assert_busy_holds_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pending && !tx_idle) |=> cfg_pending);

  assert_commit_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pending && tx_idle && !stg) |=> !cfg_pending);

  assert_direct_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd5) |=> (ctl2_q[5:0] == $past(wr_data[5:0])));

  assert_low_bits_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 3'd5) |=> $stable(ctl2_q[5:0]));

  assert_overlap_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pending && tx_idle && stg) |=> cfg_pending);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stg && !cfg_pending) |=> (!cfg_pending && $stable(mode_q) && $stable(dfmt_q)));
endmodule

bind ser_cfg_stage ser_cfg_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tx_idle(tx_idle), .mode_q(mode_q), .pval_q(pval_q),
  .dfmt_q(dfmt_q), .baud_lo_q(baud_lo_q), .ctl2_q(ctl2_q),
  .cfg_pending(cfg_pending)
);

// File: tb/ser_cfg_stage_tb.sv
module ser_cfg_stage_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       tx_idle;
  logic [7:0] mode_q, pval_q, dfmt_q, baud_lo_q, ctl2_q;
  logic       cfg_pending;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  ser_cfg_stage u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx_idle(tx_idle), .mode_q(mode_q), .pval_q(pval_q),
    .dfmt_q(dfmt_q), .baud_lo_q(baud_lo_q), .ctl2_q(ctl2_q),
    .cfg_pending(cfg_pending)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write captured at the next rising edge; returns at the falling edge after it
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 mode", {8'h0, mode_q}, 16'h0000);
    chk("R1 pval", {8'h0, pval_q}, 16'h0016);
    chk("R1 dfmt", {8'h0, dfmt_q}, 16'h0003);
    chk("R1 baud", {8'h0, baud_lo_q}, 16'h0000);
    chk("R1 ctl2", {8'h0, ctl2_q}, 16'h0000);
    chk("R1 pending", {15'h0, cfg_pending}, 16'h0000);
  endtask

  task automatic t_busy_then_commit;
    tx_idle = 1'b0;
    wr(3'd0, 8'hA5);
    chk("R2 pending after write", {15'h0, cfg_pending}, 16'h0001);
    wr(3'd1, 8'h3C);
    wr(3'd3, 8'h9B);
    wr(3'd4, 8'h02);
    wr(3'd0, 8'h5A);  // last write to mode wins
    idle_cycles(3);
    chk("R3 mode held while busy", {8'h0, mode_q}, 16'h0000);
    chk("R3 baud held while busy", {8'h0, baud_lo_q}, 16'h0000);
    chk("R3 pending held", {15'h0, cfg_pending}, 16'h0001);
    tx_idle = 1'b1;
    @(negedge clk);
    chk("R4 pending cleared", {15'h0, cfg_pending}, 16'h0000);
    chk("R10 mode last write", {8'h0, mode_q}, 16'h005A);
    chk("R4 pval", {8'h0, pval_q}, 16'h003C);
    chk("R5 baud low byte", {8'h0, baud_lo_q}, 16'h009B);
    chk("R5 ctl2 top bits", {14'h0, ctl2_q[7:6]}, 16'h0002);
  endtask

  task automatic t_idle_latency;
    tx_idle = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h07;
    @(negedge clk);  // edge k captured the write
    wr_en = 1'b0;
    chk("R4 not yet live at k", {8'h0, dfmt_q}, 16'h0003);
    chk("R2 pending at k", {15'h0, cfg_pending}, 16'h0001);
    @(negedge clk);  // edge k+1 commits
    chk("R4 live at k+1", {8'h0, dfmt_q}, 16'h0007);
    chk("R4 pending cleared k+1", {15'h0, cfg_pending}, 16'h0000);
  endtask

  task automatic t_direct_ctl2;
    tx_idle = 1'b0;
    wr(3'd5, 8'h2D);
    chk("R6 low bits immediate while busy", {10'h0, ctl2_q[5:0]}, 16'h002D);
    chk("R6 no pending", {15'h0, cfg_pending}, 16'h0000);
    chk("R6 top bits unchanged", {14'h0, ctl2_q[7:6]}, 16'h0002);
    wr(3'd4, 8'h01);
    tx_idle = 1'b1;
    idle_cycles(1);
    chk("R6 commit keeps low bits", {8'h0, ctl2_q}, 16'h006D);
  endtask

  task automatic t_break_deferred;
    tx_idle = 1'b0;
    wr(3'd2, 8'h87);
    idle_cycles(2);
    chk("R7 break not live while busy", {15'h0, dfmt_q[7]}, 16'h0000);
    tx_idle = 1'b1;
    idle_cycles(1);
    chk("R7 break live after idle", {15'h0, dfmt_q[7]}, 16'h0001);
  endtask

  task automatic t_overlap;
    tx_idle = 1'b0;
    wr(3'd0, 8'hA1);
    @(negedge clk);
    tx_idle = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'hB2;
    @(negedge clk);  // commit edge also captures B2
    wr_en = 1'b0; tx_idle = 1'b0;
    chk("R8 old value committed", {8'h0, mode_q}, 16'h00A1);
    chk("R8 still pending", {15'h0, cfg_pending}, 16'h0001);
    tx_idle = 1'b1;
    @(negedge clk);
    chk("R8 new value committed", {8'h0, mode_q}, 16'h00B2);
    chk("R8 pending cleared", {15'h0, cfg_pending}, 16'h0000);
  endtask

  task automatic t_ignored;
    tx_idle = 1'b1;
    wr(3'd6, 8'hFF);
    chk("R9 addr6 no pending", {15'h0, cfg_pending}, 16'h0000);
    wr(3'd7, 8'hFF);
    idle_cycles(1);
    chk("R9 addr7 no pending", {15'h0, cfg_pending}, 16'h0000);
    chk("R9 mode unchanged", {8'h0, mode_q}, 16'h00B2);
    chk("R9 ctl2 unchanged", {8'h0, ctl2_q}, 16'h006D);
    chk("R9 pval unchanged", {8'h0, pval_q}, 16'h003C);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; tx_idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_busy_then_commit();
    t_idle_latency();
    t_direct_ctl2();
    t_break_deferred();
    t_overlap();
    t_ignored();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule